// File: doc/BRIEF.md
# Scatter-Gather Transmit DMA Engine

This block moves outgoing frames from memory onto a byte stream. Memory holds a ring of buffer descriptors. Each descriptor is eight 32-bit words. Word 0 is the link to the next descriptor, word 1 is the buffer address, word 2 is the buffer length in bytes, and words 3 to 7 are application words. Word 3, at byte offset 12, is the status word that the engine reads and updates. Software loads the current-descriptor pointer while the engine is idle. A write to the tail-descriptor pointer then starts the walk.

For each descriptor the engine fetches words 0 to 3 and reads the buffer one word at a time. It sends the bytes out least-significant byte first, marking frame starts and ends from the status flags. It then writes the status word back with the completed flag set, and follows the link until the tail descriptor is done. A frame may span several descriptors.

Completions that ask for an interrupt feed two mechanisms:
- a coalescing counter;
- an idle-delay timer.

A descriptor that is already marked completed stops the walk and raises an error. A write of 1 to the control word at 0x40 returns the whole engine to its reset state.

Top module: `sgtx_dma`

## Requirements
- R1: After reset, the channel status reads 0, the interrupt status reads 0, the control register reads 0, `irq` is 0 and `tx_valid` is 0.
- R2: A write to the tail register at 0x10 while idle starts the walk, and channel status bit 1 (busy) reads 1. Descriptors are processed from the current pointer along the link words, up to and including the descriptor equal to the tail pointer, after which busy returns to 0.
- R3: Exactly the buffer-length number of bytes are emitted, starting at the buffer address, with the least-significant byte of each word first. A byte is transferred only when `tx_valid` and `tx_ready` are both high, and while it waits it holds its value.
- R4: `tx_sof` marks the first byte of a descriptor whose status bit 27 is set. `tx_eof` marks the last byte of a descriptor whose status bit 26 is set. A middle descriptor of a frame marks neither.
- R5: When a descriptor finishes, its status word (descriptor offset 12) is written back with bit 28 set and all other bits unchanged.
- R6: Control bits 23:16 give a threshold N, where 0 acts as 1. After N completions of descriptors with status bit 30 set, interrupt status bit 0 is set and the count restarts from zero.
- R7: Control bits 31:24 give a delay D, where 0 disables the timer. Interrupt status bit 1 sets D cycles after a completion with status bit 30, unless another such completion or a coalesce event comes first.
- R8: A write to the interrupt status register at 0x18 clears each bit that is written as 1.
- R9: `irq` is high exactly when control bit 7 is set and at least one interrupt status bit is set.
- R10: A fetched descriptor whose bit 28 is already set stops the engine. In that case no byte is emitted and no write-back is made; interrupt status bit 2 and channel status bit 0 are set.
- R11: Writes to the current (0x0C) and tail (0x10) registers while busy are ignored.
- R12: Writing 1 to 0x40 returns the engine to idle, drops `tx_valid`, and clears control, interrupt status and pointers.
- R13: Registers 0x00, 0x04 and 0x08 read back the link, buffer address and length of the most recently fetched descriptor, and 0x0C reads the current descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access completes this cycle |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_sof | output | 1 | Byte is the first of a frame |
| tx_eof | output | 1 | Byte is the last of a frame |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports.

The first is a soft reset that lands while a word sits half-sent in the byte serializer. To reach it, the bench holds `tx_ready` low during a long descriptor, waits until a byte is offered, and then writes the reset control word.

The second is the coalescing counter's restart. A three-descriptor frame runs with threshold two, which leaves one completion pending after the interrupt. The bench clears the interrupt and sends a single further descriptor, which must fire it again.

Elsewhere the sink drops ready on every third cycle, so that stalls fall in the middle of words and across descriptor boundaries.

// File: rtl/sgtx_pkg.sv
package sgtx_pkg;
  localparam int ST_IOE = 30;
  localparam int ST_CMP = 28;
  localparam int ST_SOP = 27;
  localparam int ST_EOP = 26;

  localparam logic [6:0] OFF_NXT  = 7'h00;
  localparam logic [6:0] OFF_BADR = 7'h04;
  localparam logic [6:0] OFF_BLEN = 7'h08;
  localparam logic [6:0] OFF_CUR  = 7'h0C;
  localparam logic [6:0] OFF_TAIL = 7'h10;
  localparam logic [6:0] OFF_CTRL = 7'h14;
  localparam logic [6:0] OFF_ISTS = 7'h18;
  localparam logic [6:0] OFF_CSTS = 7'h1C;
  localparam logic [6:0] OFF_SRST = 7'h40;

  localparam int CTRL_MIE    = 7;
  localparam int CTRL_THR_LO = 16;
  localparam int CTRL_DLY_LO = 24;
  localparam int FLD_W       = 8;

  localparam logic [31:0] STAT_WORD_OFS = 32'd12;

  typedef enum logic [2:0] {
    W_IDLE, W_FETCH, W_CHECK, W_RD, W_DRAIN, W_WB
  } walk_state_t;
endpackage

// File: rtl/sgtx_packer.sv
module sgtx_packer
  import sgtx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [2:0]        nbytes,
  input  logic              sof,
  input  logic              eof,
  output logic              idle,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_sof,
  output logic              tx_eof
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [2:0]        cnt_q, cnt_d;
  logic              sof_q, sof_d, eof_q, eof_d;
  logic              fire;

  assign tx_valid = (cnt_q != 3'd0);
  assign idle     = (cnt_q == 3'd0);
  assign tx_data  = sh_q[7:0];
  assign tx_sof   = sof_q;
  assign tx_eof   = eof_q && (cnt_q == 3'd1);
  assign fire     = tx_valid && tx_ready;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    sof_d = sof_q;
    eof_d = eof_q;
    if (load) begin
      sh_d  = word;
      cnt_d = nbytes;
      sof_d = sof;
      eof_d = eof;
    end else if (fire) begin
      sh_d  = sh_q >> 8;
      cnt_d = cnt_q - 3'd1;
      sof_d = 1'b0;
    end
    if (srst) begin
      sh_d  = '0;
      cnt_d = '0;
      sof_d = 1'b0;
      eof_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sof_q <= 1'b0;
      eof_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      sof_q <= sof_d;
      eof_q <= eof_d;
    end
  end

  // R3: a stalled byte holds its value
  assert_hold_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !srst) |=> (tx_valid && $stable(tx_data)));
  // R3: the walker only hands over a word when the serializer is empty
  assert_load_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> idle);
endmodule

// File: rtl/sgtx_walker.sv
module sgtx_walker
  import sgtx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srst,
  input  logic        start,
  input  logic        cur_wr,
  input  logic [31:0] cur_wdata,
  input  logic [31:0] tail_ptr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  input  logic        pk_idle,
  output logic        pk_load,
  output logic [31:0] pk_word,
  output logic [2:0]  pk_nbytes,
  output logic        pk_sof,
  output logic        pk_eof,
  output logic        busy,
  output logic        done_pulse,
  output logic        done_ioe,
  output logic        err_pulse,
  output logic [31:0] cur_ptr,
  output logic [31:0] nxt_ptr,
  output logic [31:0] buf_addr,
  output logic [31:0] buf_len
);
  localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);

  walk_state_t st_q, st_d;
  logic [31:0] cur_q, cur_d, nxt_q, nxt_d, badr_q, badr_d, blen_q, blen_d;
  logic [31:0] stat_q, stat_d;
  logic [1:0]  widx_q, widx_d;
  logic [LEN_W-1:0] off_q, off_d, rem;
  logic        last_word;

  assign rem       = blen_q[LEN_W-1:0] - off_q;
  assign last_word = (rem <= WORD_BYTES);
  assign busy      = (st_q != W_IDLE);
  assign cur_ptr   = cur_q;
  assign nxt_ptr   = nxt_q;
  assign buf_addr  = badr_q;
  assign buf_len   = blen_q;

  always_comb begin
    st_d = st_q; cur_d = cur_q; nxt_d = nxt_q; badr_d = badr_q;
    blen_d = blen_q; stat_d = stat_q; widx_d = widx_q; off_d = off_q;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = cur_q; mem_wdata = '0;
    pk_load = 1'b0; pk_word = mem_rdata; pk_nbytes = 3'd4;
    pk_sof = 1'b0; pk_eof = 1'b0;
    done_pulse = 1'b0; done_ioe = 1'b0; err_pulse = 1'b0;
    unique case (st_q)
      W_IDLE: begin
        if (cur_wr) cur_d = cur_wdata;
        if (start) begin
          widx_d = 2'd0;
          st_d   = W_FETCH;
        end
      end
      W_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + {28'd0, widx_q, 2'b00};
        if (mem_ack) begin
          unique case (widx_q)
            2'd0: nxt_d  = mem_rdata;
            2'd1: badr_d = mem_rdata;
            2'd2: blen_d = mem_rdata;
            default: stat_d = mem_rdata;
          endcase
          if (widx_q == 2'd3) st_d = W_CHECK;
          else widx_d = widx_q + 2'd1;
        end
      end
      W_CHECK: begin
        if (stat_q[ST_CMP]) begin
          err_pulse = 1'b1;
          st_d      = W_IDLE;
        end else if (blen_q[LEN_W-1:0] == '0) begin
          st_d = W_WB;
        end else begin
          off_d = '0;
          st_d  = W_RD;
        end
      end
      W_RD: begin
        mem_req  = pk_idle;
        mem_addr = badr_q + 32'(off_q);
        if (mem_ack) begin
          pk_load   = 1'b1;
          pk_nbytes = last_word ? rem[2:0] : 3'd4;
          pk_sof    = stat_q[ST_SOP] && (off_q == '0);
          pk_eof    = stat_q[ST_EOP] && last_word;
          off_d     = off_q + WORD_BYTES;
          st_d      = last_word ? W_DRAIN : W_RD;
        end
      end
      W_DRAIN: begin
        if (pk_idle) st_d = W_WB;
      end
      W_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q + STAT_WORD_OFS;
        mem_wdata = stat_q | (32'd1 << ST_CMP);
        if (mem_ack) begin
          done_pulse = 1'b1;
          done_ioe   = stat_q[ST_IOE];
          if (cur_q == tail_ptr) begin
            st_d = W_IDLE;
          end else begin
            cur_d  = nxt_q;
            widx_d = 2'd0;
            st_d   = W_FETCH;
          end
        end
      end
      default: st_d = W_IDLE;
    endcase
    if (srst) begin
      st_d = W_IDLE; cur_d = '0; nxt_d = '0; badr_d = '0; blen_d = '0;
      stat_d = '0; widx_d = '0; off_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE; cur_q <= '0; nxt_q <= '0; badr_q <= '0;
      blen_q <= '0; stat_q <= '0; widx_q <= '0; off_q <= '0;
    end else begin
      st_q <= st_d; cur_q <= cur_d; nxt_q <= nxt_d; badr_q <= badr_d;
      blen_q <= blen_d; stat_q <= stat_d; widx_q <= widx_d; off_q <= off_d;
    end
  end

  // R2: completing the tail descriptor ends the walk
  assert_stop_at_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && (cur_ptr == tail_ptr) && !srst) |=> !busy);
  // R10: a pre-completed descriptor halts the engine
  assert_err_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !srst) |=> !busy);
  // R10: no write-back right after an error stop
  assert_err_no_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !mem_we);
endmodule

// File: rtl/sgtx_regs.sv
module sgtx_regs
  import sgtx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [6:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        busy,
  input  logic        done_ioe,
  input  logic        err_pulse,
  input  logic [31:0] cur_ptr,
  input  logic [31:0] nxt_ptr,
  input  logic [31:0] buf_addr,
  input  logic [31:0] buf_len,
  output logic        srst,
  output logic        start,
  output logic        cur_wr,
  output logic [31:0] tail_ptr,
  output logic        irq
);
  logic [31:0] ctrl_q, ctrl_d, tail_q, tail_d;
  logic [2:0]  ists_q, ists_d;
  logic        err_q, err_d;
  logic [FLD_W-1:0] coal_q, coal_d, dcnt_q, dcnt_d, thr, dly;
  logic        arm_q, arm_d;
  logic        ists_w1c;

  assign srst     = reg_we && (reg_addr == OFF_SRST) && reg_wdata[0];
  assign start    = reg_we && (reg_addr == OFF_TAIL) && !busy;
  assign cur_wr   = reg_we && (reg_addr == OFF_CUR) && !busy;
  assign ists_w1c = reg_we && (reg_addr == OFF_ISTS);
  assign tail_ptr = tail_q;
  assign dly      = ctrl_q[CTRL_DLY_LO +: FLD_W];
  assign thr      = (ctrl_q[CTRL_THR_LO +: FLD_W] == '0) ? FLD_W'(1)
                                                         : ctrl_q[CTRL_THR_LO +: FLD_W];
  assign irq      = ctrl_q[CTRL_MIE] && (ists_q != 3'd0);

  always_comb begin
    unique case (reg_addr)
      OFF_NXT:  reg_rdata = nxt_ptr;
      OFF_BADR: reg_rdata = buf_addr;
      OFF_BLEN: reg_rdata = buf_len;
      OFF_CUR:  reg_rdata = cur_ptr;
      OFF_TAIL: reg_rdata = tail_q;
      OFF_CTRL: reg_rdata = ctrl_q;
      OFF_ISTS: reg_rdata = {29'd0, ists_q};
      OFF_CSTS: reg_rdata = {30'd0, busy, err_q};
      default:  reg_rdata = '0;
    endcase
  end

  always_comb begin
    ctrl_d = ctrl_q; tail_d = tail_q; ists_d = ists_q; err_d = err_q;
    coal_d = coal_q; dcnt_d = dcnt_q; arm_d = arm_q;
    if (reg_we && (reg_addr == OFF_CTRL)) ctrl_d = reg_wdata;
    if (start) begin
      tail_d = reg_wdata;
      err_d  = 1'b0;
    end
    if (ists_w1c) ists_d = ists_q & ~reg_wdata[2:0];
    if (done_ioe) begin
      if (({1'b0, coal_q} + 9'd1) >= {1'b0, thr}) begin
        ists_d[0] = 1'b1;
        coal_d    = '0;
        arm_d     = 1'b0;
      end else begin
        coal_d = coal_q + FLD_W'(1);
        arm_d  = (dly != '0);
        dcnt_d = '0;
      end
    end else if (arm_q) begin
      dcnt_d = dcnt_q + FLD_W'(1);
      if ((dcnt_q + FLD_W'(1)) == dly) begin
        ists_d[1] = 1'b1;
        arm_d     = 1'b0;
      end
    end
    if (err_pulse) begin
      ists_d[2] = 1'b1;
      err_d     = 1'b1;
    end
    if (srst) begin
      ctrl_d = '0; tail_d = '0; ists_d = '0; err_d = 1'b0;
      coal_d = '0; dcnt_d = '0; arm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; tail_q <= '0; ists_q <= '0; err_q <= 1'b0;
      coal_q <= '0; dcnt_q <= '0; arm_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d; tail_q <= tail_d; ists_q <= ists_d; err_q <= err_d;
      coal_q <= coal_d; dcnt_q <= dcnt_d; arm_q <= arm_d;
    end
  end

  // R10: an error stop is visible in the interrupt status
  assert_err_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !srst) |=> ists_q[2]);
  // R8: writing 1 to the coalesce bit clears it unless a new event lands
  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ists_w1c && reg_wdata[0] && !done_ioe && !srst) |=> !ists_q[0]);
  // R11: tail writes while busy leave the tail untouched
  assert_busy_tail_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == OFF_TAIL) && busy && !srst) |=> $stable(tail_q));
endmodule

// File: rtl/sgtx_dma.sv
module sgtx_dma
  import sgtx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [6:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        tx_sof,
  output logic        tx_eof,
  output logic        irq
);
  logic        srst, start, cur_wr, busy, done_pulse, done_ioe, err_pulse;
  logic [31:0] tail_ptr, cur_ptr, nxt_ptr, buf_addr, buf_len;
  logic        pk_idle, pk_load, pk_sof, pk_eof;
  logic [31:0] pk_word;
  logic [2:0]  pk_nbytes;

  sgtx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .done_ioe(done_ioe), .err_pulse(err_pulse), .cur_ptr(cur_ptr),
    .nxt_ptr(nxt_ptr), .buf_addr(buf_addr), .buf_len(buf_len),
    .srst(srst), .start(start), .cur_wr(cur_wr), .tail_ptr(tail_ptr),
    .irq(irq)
  );

  sgtx_walker #(.LEN_W(LEN_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .srst(srst), .start(start), .cur_wr(cur_wr),
    .cur_wdata(reg_wdata), .tail_ptr(tail_ptr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .pk_idle(pk_idle),
    .pk_load(pk_load), .pk_word(pk_word), .pk_nbytes(pk_nbytes),
    .pk_sof(pk_sof), .pk_eof(pk_eof), .busy(busy), .done_pulse(done_pulse),
    .done_ioe(done_ioe), .err_pulse(err_pulse), .cur_ptr(cur_ptr),
    .nxt_ptr(nxt_ptr), .buf_addr(buf_addr), .buf_len(buf_len)
  );

  sgtx_packer #(.WORD_W(32)) u_packer (
    .clk(clk), .rst_n(rst_n), .srst(srst), .load(pk_load), .word(pk_word),
    .nbytes(pk_nbytes), .sof(pk_sof), .eof(pk_eof), .idle(pk_idle),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sof(tx_sof), .tx_eof(tx_eof)
  );
endmodule

// File: tb/sgtx_dma_tb_top.sv
module sgtx_dma_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0] tx_data;
  logic tx_valid, tx_sof, tx_eof, irq;
  logic tx_ready = 1'b0;
  logic hold_ready = 1'b0;

  logic [31:0] mem [0:255];
  logic [9:0] expq [$];
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  sgtx_dma dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .irq(irq)
  );

  // memory model: one wait cycle, then acknowledge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as bytes leave the design
  always @(negedge clk) begin
    cyc++;
    tx_ready = !hold_ready && ((cyc % 3) != 0);
    if (rst_n && tx_valid && tx_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R3 unexpected byte", {22'd0, tx_sof, tx_eof, tx_data}, 32'd0);
      end else begin
        logic [9:0] e;
        e = expq.pop_front();
        chk({tx_sof, tx_eof, tx_data} == e, "R3/R4 stream byte",
            {22'd0, tx_sof, tx_eof, tx_data}, {22'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(7'h1C, s);
      if (!s[1]) break;
    end
  endtask

  task automatic set_desc(input int a, input logic [31:0] nx, input logic [31:0] b,
                          input logic [31:0] len, input logic [31:0] st);
    mem[a/4] = nx; mem[a/4+1] = b; mem[a/4+2] = len; mem[a/4+3] = st;
    for (int k = 4; k < 8; k++) mem[a/4+k] = '0;
  endtask

  // driver: fills a buffer and pushes its expected bytes
  task automatic fill_buf(input int b, input int len, input int seed, input bit sop,
                          input bit eop, input bit expect_it);
    for (int i = 0; i < len; i++) begin
      logic [7:0] v;
      v = 8'(seed + 7 * i);
      mem[(b + i) / 4][8*((b + i) % 4) +: 8] = v;
      if (expect_it) expq.push_back({sop && (i == 0), eop && (i == len - 1), v});
    end
  endtask

  localparam logic [31:0] F_IOE = 32'h4000_0000, F_CMP = 32'h1000_0000,
                          F_SOP = 32'h0800_0000, F_EOP = 32'h0400_0000;

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(7'h1C, r); chk(r == 0, "R1 channel status", r, 0);
    rd(7'h18, r); chk(r == 0, "R1 irq status", r, 0);
    rd(7'h14, r); chk(r == 0, "R1 control", r, 0);
    chk(irq == 0 && tx_valid == 0, "R1 irq/tx_valid", {30'd0, irq, tx_valid}, 0);

    // single descriptor, threshold 1
    set_desc(32'h100, 32'h120, 32'h200, 6, F_SOP | F_EOP | F_IOE);
    fill_buf(32'h200, 6, 8'h11, 1, 1, 1);
    wr(7'h14, 32'h0001_0080);
    wr(7'h0C, 32'h100);
    wr(7'h10, 32'h100);
    rd(7'h1C, r); chk(r[1] == 1'b1, "R2 busy after tail write", r, 32'h2);
    wait_idle();
    chk(mem[32'h10C/4] == (F_SOP | F_EOP | F_IOE | F_CMP), "R5 write-back",
        mem[32'h10C/4], F_SOP | F_EOP | F_IOE | F_CMP);
    rd(7'h18, r); chk(r == 32'h1, "R6 coalesce at threshold 1", r, 1);
    chk(irq == 1'b1, "R9 irq with master enable", {31'd0, irq}, 1);
    rd(7'h00, r); chk(r == 32'h120, "R13 link readback", r, 32'h120);
    rd(7'h04, r); chk(r == 32'h200, "R13 buffer address readback", r, 32'h200);
    rd(7'h08, r); chk(r == 6, "R13 length readback", r, 6);
    wr(7'h18, 32'h1);
    rd(7'h18, r); chk(r == 0, "R8 write-one-to-clear", r, 0);
    chk(irq == 1'b0, "R9 irq drops", {31'd0, irq}, 0);

    // three-descriptor frame, threshold 2, writes while busy
    set_desc(32'h120, 32'h140, 32'h240, 5, F_SOP | F_IOE);
    set_desc(32'h140, 32'h160, 32'h260, 4, F_IOE);
    set_desc(32'h160, 32'h100, 32'h280, 3, F_EOP | F_IOE);
    fill_buf(32'h240, 5, 8'h30, 1, 0, 1);
    fill_buf(32'h260, 4, 8'h50, 0, 0, 1);
    fill_buf(32'h280, 3, 8'h70, 0, 1, 1);
    wr(7'h14, 32'h0002_0080);
    wr(7'h0C, 32'h120);
    wr(7'h10, 32'h160);
    wr(7'h0C, 32'h000);
    wr(7'h10, 32'h120);
    wait_idle();
    rd(7'h0C, r); chk(r == 32'h160, "R11 current ignored while busy", r, 32'h160);
    rd(7'h10, r); chk(r == 32'h160, "R11 tail ignored while busy", r, 32'h160);
    chk(mem[32'h14C/4] == (F_IOE | F_CMP), "R5 middle write-back", mem[32'h14C/4], F_IOE | F_CMP);
    rd(7'h18, r); chk(r == 32'h1, "R6 coalesce after two of three", r, 1);
    wr(7'h18, 32'h1);
    set_desc(32'h100, 32'h120, 32'h2A0, 2, F_SOP | F_EOP | F_IOE);
    fill_buf(32'h2A0, 2, 8'h90, 1, 1, 1);
    wr(7'h0C, 32'h100);
    wr(7'h10, 32'h100);
    wait_idle();
    rd(7'h18, r); chk(r == 32'h1, "R6 counter restarted", r, 1);
    wr(7'h18, 32'h7);

    // delay timer
    set_desc(32'h100, 32'h120, 32'h2A0, 2, F_SOP | F_EOP | F_IOE);
    fill_buf(32'h2A0, 2, 8'hA0, 1, 1, 1);
    wr(7'h14, 32'h1408_0080);
    wr(7'h0C, 32'h100);
    wr(7'h10, 32'h100);
    wait_idle();
    rd(7'h18, r); chk(r == 0, "R7 no delay event yet", r, 0);
    repeat (40) @(negedge clk);
    rd(7'h18, r); chk(r == 32'h2, "R7 delay event", r, 2);
    wr(7'h18, 32'h2);

    // pre-completed descriptor
    set_desc(32'h180, 32'h100, 32'h2C0, 4, F_CMP | F_SOP | F_EOP);
    fill_buf(32'h2C0, 4, 8'hC0, 1, 1, 0);
    wr(7'h14, 32'h0000_0080);
    wr(7'h0C, 32'h180);
    wr(7'h10, 32'h180);
    wait_idle();
    rd(7'h1C, r); chk(r == 32'h1, "R10 channel error, not busy", r, 1);
    rd(7'h18, r); chk(r == 32'h4, "R10 error interrupt", r, 4);
    chk(irq == 1'b1, "R10 irq raised", {31'd0, irq}, 1);
    chk(mem[32'h18C/4] == (F_CMP | F_SOP | F_EOP), "R10 no write-back",
        mem[32'h18C/4], F_CMP | F_SOP | F_EOP);

    // soft reset mid-stream
    set_desc(32'h1A0, 32'h100, 32'h300, 40, F_SOP | F_EOP);
    fill_buf(32'h300, 40, 8'h05, 1, 1, 0);
    hold_ready = 1'b1;
    wr(7'h0C, 32'h1A0);
    wr(7'h10, 32'h1A0);
    repeat (30) @(negedge clk);
    chk(tx_valid == 1'b1, "R12 byte pending before reset", {31'd0, tx_valid}, 1);
    wr(7'h40, 32'h1);
    rd(7'h1C, r); chk(r == 0, "R12 idle after soft reset", r, 0);
    chk(tx_valid == 1'b0, "R12 stream dropped", {31'd0, tx_valid}, 0);
    rd(7'h14, r); chk(r == 0, "R12 control cleared", r, 0);
    rd(7'h18, r); chk(r == 0, "R12 irq status cleared", r, 0);
    rd(7'h0C, r); chk(r == 0, "R12 pointer cleared", r, 0);
    chk(irq == 1'b0, "R12 irq low", {31'd0, irq}, 0);
    hold_ready = 1'b0;
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R3 all expected bytes seen", expq.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule